// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block collects 96 level-sensitive interrupt lines, organised as three banks of 32, and presents them to a processor as two request outputs: a normal request and a fast request. Each line carries a 6-bit priority and a routing bit that chooses the output class. A priority resolver per class picks the winning line among pending, unmasked lines. That line's number is latched into a source-code register when the class output fires.

After an output fires, its class is disarmed. Software reads the source code, services the line, and then re-arms the class through the control register. Re-arming drops the output and evaluates the pending state again.

Software drives the block through a simple 32-bit register bus. Read data and error status return one cycle after the access. Each bank has its own mask with atomic set and clear aliases, software-raised interrupts with set and clear aliases, a raw-input view, and a pending view for each class. Further controls are a global hold-off bit, a soft reset, and two small idle/autoidle fields that are stored only.

Top module: `lvl_intc`

## Requirements
- R1: After reset, every bank mask reads 0xFFFFFFFF, both outputs are low, both source codes read 0, the control register reads 0, and every line configuration reads 0.
- R2: Address 0x00 reads 0x21 and 0x14 reads 1. Address 0x4C reads 0 and accepts writes without effect. Address 0x50 stores a 2-bit idle value. Address 0x10 bit0 stores autoidle, and reads of 0x10 return only that bit.
- R3: Bank b occupies 0x80+0x20*b with these word offsets: 0x00 raw input levels, 0x04 mask, 0x08 mask-clear, 0x0C mask-set, 0x10 software-set, 0x14 software-clear, 0x18 normal pending view, 0x1C fast pending view. Bit k of each bank register is line 32*b+k. Mask-clear, mask-set and software-clear read 0. Software-set reads the software bits.
- R4: Line n is configured at 0x100+4*n. Bits[7:2] hold the priority and bit0 routes the line to the fast class (1) or the normal class (0). Bit1 reads 0.
- R5: Within a class, the lowest priority value wins among pending, unmasked lines. On equal priority the highest line number wins. The source code (0x40 normal, 0x44 fast) is the winning line number.
- R6: When an evaluation finds an armed class with a winner, that output rises two clock edges after the triggering input change or bus write, and the class disarms. The output then stays high until control bit0 (normal) or bit1 (fast) is written as 1. That write drops the output on the next edge, re-arms the class and evaluates it again.
- R7: Evaluation happens on an input rising edge, a software-set write, a mask write, a mask-clear write or a re-arm. A mask-set write and a change of the global mask do not trigger evaluation.
- R8: Control bit2 is a global hold-off. While it is 1, neither output can fire. It reads back at bit2.
- R9: The normal view reads pending AND NOT mask AND NOT fast-route. The fast view reads pending AND NOT mask AND fast-route.
- R10: A rising input sets its pending bit. When any input of a bank falls, that bank's pending bits become its raw inputs OR its software bits.
- R11: A software-set write ORs the data into both the software bits and the pending bits. A software-clear write clears the given software bits and then sets pending to the remaining software bits AND the raw inputs.
- R12: Reading a source code leaves pending state and outputs unchanged.
- R13: The error flag is high for one cycle after any of these accesses, and the access changes no state: a write to 0x00, 0x14, 0x40, 0x44 or a bank's raw or pending view; an access to a bank index of 3 or more; an access to an unmapped address.
- R14: Writing 1 to bit1 of 0x10 returns all state, including autoidle, to its reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 96 | Level interrupt inputs, line n at bit n |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Access error, the cycle after the access |
| irq_norm | output | 1 | Normal-class interrupt request |
| irq_fast | output | 1 | Fast-class interrupt request |

## Verification
The bench sweeps every line alone and checks the raised output, the source code, the pending view and the bank-wide recompute when the line falls. A design that got the line-to-bit mapping or the fall recompute wrong would report the wrong code or leave a stale pending bit. It also sets all 96 lines at once under two computed priority and routing patterns, one with many equal priorities. A design with a reversed tie-break or a misrouted class would then report the wrong code on one of the two outputs. Further sequences check that a mask-set write and a global-mask release evaluate nothing while a mask-clear write fires the output. They also check that a software-clear write wipes pending bits that a still-high input holds. A design that evaluated on every change, or built pending from raw inputs alone, would fire early or keep those bits.

// File: rtl/lvl_intc_pkg.sv
`timescale 1ns/1ps
package lvl_intc_pkg;

    localparam int CLS_NORM = 0;
    localparam int CLS_FAST = 1;

    // global register word indices (byte address / 4)
    localparam int GW_REV     = 0;
    localparam int GW_SYSCFG  = 4;
    localparam int GW_SYSSTAT = 5;
    localparam int GW_CODE_N  = 16;
    localparam int GW_CODE_F  = 17;
    localparam int GW_CTRL    = 18;
    localparam int GW_PROT    = 19;
    localparam int GW_IDLE    = 20;

    localparam int BANK_BASE  = 128;
    localparam int LINE_BASE  = 256;

    typedef enum logic [2:0] {
        BR_RAW  = 3'd0,
        BR_MASK = 3'd1,
        BR_MCLR = 3'd2,
        BR_MSET = 3'd3,
        BR_SSET = 3'd4,
        BR_SCLR = 3'd5,
        BR_PNRM = 3'd6,
        BR_PFST = 3'd7
    } bank_reg_e;

    typedef struct packed {
        logic mask_wr;
        logic mask_clr;
        logic mask_set;
        logic sw_set;
        logic sw_clr;
    } bank_wr_t;

endpackage

// File: rtl/lvl_intc_bank.sv
`timescale 1ns/1ps
module lvl_intc_bank
    import lvl_intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] raw_in,
    input  bank_wr_t     cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] inputs_q,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] swi_q,
    output logic [W-1:0] mask_q,
    output logic         rise_any
);

    logic [W-1:0] rise, pend_n, swi_n, mask_n;
    logic         fall_any;

    always_comb begin
        rise     = raw_in & ~inputs_q;
        fall_any = |(inputs_q & ~raw_in);
        rise_any = |rise;
        // input side first: a fall rebuilds the bank from levels plus software bits
        pend_n = fall_any ? (raw_in | swi_q) : (pend_q | rise);
        swi_n  = swi_q;
        if (cmd.sw_set) begin
            swi_n  = swi_n | wdata;
            pend_n = pend_n | wdata;
        end
        if (cmd.sw_clr) begin
            swi_n  = swi_n & ~wdata;
            pend_n = swi_n & raw_in;
        end
        mask_n = mask_q;
        if (cmd.mask_wr)  mask_n = wdata;
        if (cmd.mask_clr) mask_n = mask_q & ~wdata;
        if (cmd.mask_set) mask_n = mask_q | wdata;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            inputs_q <= '0;
            pend_q   <= '0;
            swi_q    <= '0;
            mask_q   <= '1;
        end else begin
            inputs_q <= raw_in;
            pend_q   <= pend_n;
            swi_q    <= swi_n;
            mask_q   <= mask_n;
        end
    end

    // R10/R11: every pending bit is backed by a held input or a software bit
    a_r10_pending_has_source: assert property (@(posedge clk) disable iff (clr)
        (pend_q & ~(inputs_q | swi_q)) == '0);

endmodule

// File: rtl/lvl_intc_resolve.sv
`timescale 1ns/1ps
module lvl_intc_resolve #(
    parameter int N  = 96,
    parameter int PW = 6,
    parameter int CW = 7
) (
    input  logic [N-1:0]    act,
    input  logic [N*PW-1:0] prio,
    output logic            any,
    output logic [CW-1:0]   code
);

    logic [PW:0] best;

    always_comb begin
        any  = |act;
        best = {1'b1, {PW{1'b0}}};
        code = '0;
        // ascending scan with <=: later lines win ties
        for (int i = 0; i < N; i++) begin
            if (act[i] && ({1'b0, prio[i*PW +: PW]} <= best)) begin
                best = {1'b0, prio[i*PW +: PW]};
                code = CW'(i);
            end
        end
    end

endmodule

// File: rtl/lvl_intc_agree.sv
`timescale 1ns/1ps
module lvl_intc_agree #(
    parameter int N  = 96,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          rearm,
    input  logic          eval,
    input  logic          block,
    input  logic          any_act,
    input  logic [CW-1:0] win,
    output logic          out_q,
    output logic [CW-1:0] code_q
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            armed_q <= 1'b1;
            out_q   <= 1'b0;
            code_q  <= '0;
        end else if (rearm) begin
            armed_q <= 1'b1;
            out_q   <= 1'b0;
        end else if (eval && armed_q && any_act && !block) begin
            armed_q <= 1'b0;
            out_q   <= 1'b1;
            code_q  <= win;
        end
    end

    a_r6_fires_only_when_armed: assert property (@(posedge clk) disable iff (clr)
        $rose(out_q) |-> $past(armed_q));

    a_r8_holdoff_blocks_fire: assert property (@(posedge clk) disable iff (clr)
        $rose(out_q) |-> !$past(block));

    a_r5_code_in_range: assert property (@(posedge clk) disable iff (clr)
        out_q |-> (int'(code_q) < N));

endmodule

// File: rtl/lvl_intc.sv
`timescale 1ns/1ps
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int         NBANK  = 3,
    parameter int         LPB    = 32,
    parameter int         PRIO_W = 6,
    parameter int         DW     = 32,
    parameter int         AW     = 12,
    parameter logic [7:0] REV_ID = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NBANK*LPB-1:0] irq_lines,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_err,
    output logic                 irq_norm,
    output logic                 irq_fast
);

    localparam int NLINE = NBANK * LPB;
    localparam int CW    = $clog2(NLINE);
    localparam int NCLS  = 2;

    // ---------------- state ----------------
    logic              gmask_q, autoidle_q;
    logic [1:0]        idle_q;
    logic [PRIO_W-1:0] prio_q [NLINE];
    logic [NLINE-1:0]  fast_q;
    logic [NCLS-1:0]   eval_q;

    logic [LPB-1:0] raw_b [NBANK];
    logic [LPB-1:0] pend_b [NBANK];
    logic [LPB-1:0] swi_b [NBANK];
    logic [LPB-1:0] mask_b [NBANK];
    logic [NBANK-1:0] rise_b;
    bank_wr_t         bank_cmd [NBANK];

    logic [NLINE-1:0]    pend_all, mask_all;
    logic [NLINE*PRIO_W-1:0] prio_flat;
    logic [NLINE-1:0]    act_c [NCLS];
    logic [NCLS-1:0]     any_c, out_c;
    logic [CW-1:0]       win_c [NCLS];
    logic [CW-1:0]       code_c [NCLS];

    // ---------------- decode ----------------
    logic            wr_en, rd_en, hit, ro, srst, clr;
    logic            ctrl_wr, cfg_wr, idle_wr, line_wr, eval_now;
    logic [DW-1:0]   rd_val;
    logic [CW-1:0]   lsel;
    bank_reg_e       breg;
    int              word, bidx, lidx, addr_i;

    always_comb begin
        wr_en   = bus_sel & bus_wr;
        rd_en   = bus_sel & ~bus_wr;
        addr_i  = int'(bus_addr);
        word    = addr_i >> 2;
        bidx    = int'(bus_addr[6:5]);
        breg    = bank_reg_e'(bus_addr[4:2]);
        lidx    = (addr_i - LINE_BASE) >> 2;
        hit     = 1'b0;
        ro      = 1'b0;
        rd_val  = '0;
        ctrl_wr = 1'b0;
        cfg_wr  = 1'b0;
        idle_wr = 1'b0;
        line_wr = 1'b0;
        lsel    = '0;
        for (int b = 0; b < NBANK; b++) bank_cmd[b] = '0;

        if (addr_i < BANK_BASE) begin
            hit = 1'b1;
            case (word)
                GW_REV:     begin rd_val = DW'(REV_ID); ro = 1'b1; end
                GW_SYSCFG:  begin rd_val = DW'(autoidle_q); cfg_wr = wr_en; end
                GW_SYSSTAT: begin rd_val = DW'(1); ro = 1'b1; end
                GW_CODE_N:  begin rd_val = DW'(code_c[CLS_NORM]); ro = 1'b1; end
                GW_CODE_F:  begin rd_val = DW'(code_c[CLS_FAST]); ro = 1'b1; end
                GW_CTRL:    begin rd_val = DW'({gmask_q, 2'b00}); ctrl_wr = wr_en; end
                GW_PROT:    rd_val = '0;
                GW_IDLE:    begin rd_val = DW'(idle_q); idle_wr = wr_en; end
                default:    hit = 1'b0;
            endcase
        end else if (addr_i < LINE_BASE) begin
            if (bidx < NBANK) begin
                hit = 1'b1;
                for (int b = 0; b < NBANK; b++) begin
                    if (b == bidx) begin
                        case (breg)
                            BR_RAW:  begin rd_val = DW'(raw_b[b]); ro = 1'b1; end
                            BR_MASK: begin rd_val = DW'(mask_b[b]); bank_cmd[b].mask_wr = wr_en; end
                            BR_MCLR: bank_cmd[b].mask_clr = wr_en;
                            BR_MSET: bank_cmd[b].mask_set = wr_en;
                            BR_SSET: begin rd_val = DW'(swi_b[b]); bank_cmd[b].sw_set = wr_en; end
                            BR_SCLR: bank_cmd[b].sw_clr = wr_en;
                            BR_PNRM: begin
                                rd_val = DW'(pend_b[b] & ~mask_b[b] & ~fast_q[b*LPB +: LPB]);
                                ro = 1'b1;
                            end
                            default: begin
                                rd_val = DW'(pend_b[b] & ~mask_b[b] & fast_q[b*LPB +: LPB]);
                                ro = 1'b1;
                            end
                        endcase
                    end
                end
            end
        end else if (lidx < NLINE) begin
            hit     = 1'b1;
            lsel    = CW'(lidx);
            rd_val[2 +: PRIO_W] = prio_q[lsel];
            rd_val[0] = fast_q[lsel];
            line_wr = wr_en;
        end

        srst = cfg_wr & bus_wdata[1];
    end

    assign clr = rst | srst;

    always_comb begin
        eval_now = |rise_b;
        for (int b = 0; b < NBANK; b++)
            eval_now = eval_now | bank_cmd[b].sw_set | bank_cmd[b].mask_wr | bank_cmd[b].mask_clr;
    end

    // ---------------- banks ----------------
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        lvl_intc_bank #(.W(LPB)) u_bank (
            .clk      (clk),
            .clr      (clr),
            .raw_in   (irq_lines[b*LPB +: LPB]),
            .cmd      (bank_cmd[b]),
            .wdata    (bus_wdata[LPB-1:0]),
            .inputs_q (raw_b[b]),
            .pend_q   (pend_b[b]),
            .swi_q    (swi_b[b]),
            .mask_q   (mask_b[b]),
            .rise_any (rise_b[b])
        );
        assign pend_all[b*LPB +: LPB] = pend_b[b];
        assign mask_all[b*LPB +: LPB] = mask_b[b];
    end

    for (genvar i = 0; i < NLINE; i++) begin : g_flat
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // ---------------- per-class resolve and handshake ----------------
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        if (c == CLS_FAST) begin : g_f
            assign act_c[c] = pend_all & ~mask_all & fast_q;
        end else begin : g_n
            assign act_c[c] = pend_all & ~mask_all & ~fast_q;
        end

        lvl_intc_resolve #(.N(NLINE), .PW(PRIO_W), .CW(CW)) u_res (
            .act  (act_c[c]),
            .prio (prio_flat),
            .any  (any_c[c]),
            .code (win_c[c])
        );

        lvl_intc_agree #(.N(NLINE), .CW(CW)) u_agr (
            .clk     (clk),
            .clr     (clr),
            .rearm   (ctrl_wr & bus_wdata[c]),
            .eval    (eval_q[c]),
            .block   (gmask_q),
            .any_act (any_c[c]),
            .win     (win_c[c]),
            .out_q   (out_c[c]),
            .code_q  (code_c[c])
        );

        a_r5_winner_is_active: assert property (@(posedge clk) disable iff (clr)
            any_c[c] |-> act_c[c][win_c[c]]);
    end

    assign irq_norm = out_c[CLS_NORM];
    assign irq_fast = out_c[CLS_FAST];

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (clr) begin
            gmask_q    <= 1'b0;
            autoidle_q <= 1'b0;
            idle_q     <= 2'b00;
            fast_q     <= '0;
            eval_q     <= '0;
            for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
        end else begin
            if (ctrl_wr) gmask_q    <= bus_wdata[2];
            if (cfg_wr)  autoidle_q <= bus_wdata[0];
            if (idle_wr) idle_q     <= bus_wdata[1:0];
            if (line_wr) begin
                prio_q[lsel] <= bus_wdata[2 +: PRIO_W];
                fast_q[lsel] <= bus_wdata[0];
            end
            for (int c = 0; c < NCLS; c++)
                eval_q[c] <= eval_now | (ctrl_wr & bus_wdata[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_en ? rd_val : '0;
            bus_err   <= bus_sel & (~hit | (bus_wr & ro));
        end
    end

    a_r13_ro_write_flags_error: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && ro) |=> bus_err);

    a_r13_unmapped_flags_error: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !hit) |=> bus_err);

endmodule

// File: tb/lvl_intc_test.sv
`timescale 1ns/1ps
module lvl_intc_test;

    localparam int NL = 96;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] irq_lines;
    logic          bus_sel, bus_wr;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_err, irq_norm, irq_fast;

    always #2 clk = ~clk;

    lvl_intc uut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    int total = 0;
    int bad   = 0;
    logic [31:0] q;
    logic        e;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        q = bus_rdata; e = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a);
        acc(1'b0, a, 32'h0);
    endtask

    function automatic logic [11:0] ba(input int b, input int off);
        return 12'(128 + 32 * b + off);
    endfunction

    function automatic int pr(input int pat, input int i);
        return (pat == 0) ? ((i * 37 + 11) % 64) : ((i * 13) % 8);
    endfunction

    function automatic logic fr(input int pat, input int i);
        return (pat == 0) ? (i % 5 == 0) : (i % 3 == 1);
    endfunction

    function automatic int winner(input int pat, input logic cls);
        int best = 64;
        int code = 0;
        for (int i = 0; i < NL; i++)
            if (fr(pat, i) == cls && pr(pat, i) <= best) begin
                best = pr(pat, i);
                code = i;
            end
        return code;
    endfunction

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; irq_lines = '0;
        bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq_norm", 32'(irq_norm), 0);
        chk("R1 irq_fast", 32'(irq_fast), 0);
        for (int b = 0; b < 3; b++) begin rd(ba(b, 4)); chk("R1 mask", q, 32'hFFFF_FFFF); end
        rd(12'h040); chk("R1 code normal", q, 0);
        rd(12'h044); chk("R1 code fast", q, 0);
        rd(12'h048); chk("R1 control", q, 0);
        rd(12'h144); chk("R1 line cfg", q, 0);

        // R2 identification and stored-only fields
        rd(12'h000); chk("R2 revision", q, 32'h21);
        rd(12'h014); chk("R2 status", q, 1);
        wr(12'h04C, 1); chk("R2 protection write err", 32'(e), 0);
        rd(12'h04C); chk("R2 protection", q, 0);
        wr(12'h050, 3); rd(12'h050); chk("R2 idle", q, 3);
        wr(12'h010, 32'h5); rd(12'h010); chk("R2 autoidle only", q, 1);

        // R3 unmask all banks, aliases read 0
        for (int b = 0; b < 3; b++) begin
            wr(ba(b, 4), 0); rd(ba(b, 4)); chk("R3 mask write", q, 0);
        end
        rd(ba(0, 8));  chk("R3 mask-clear reads 0", q, 0);
        rd(ba(0, 12)); chk("R3 mask-set reads 0", q, 0);

        // single-line sweep: R3 R5 R6 R9 R10
        for (int i = 0; i < NL; i++) begin
            irq_lines[i] = 1'b1;
            tick(); tick();
            chk("R6 normal fires", 32'(irq_norm), 1);
            chk("R6 fast idle", 32'(irq_fast), 0);
            rd(ba(i / 32, 0));  chk("R3 raw view", q, 32'(1) << (i % 32));
            rd(12'h040);        chk("R5 code", q, 32'(i));
            chk("R12 output kept", 32'(irq_norm), 1);
            rd(ba(i / 32, 24)); chk("R9 normal pending", q, 32'(1) << (i % 32));
            irq_lines[i] = 1'b0;
            tick();
            rd(ba(i / 32, 24)); chk("R10 fall recompute", q, 0);
            wr(12'h048, 1);
            tick();
            chk("R6 rearm drops", 32'(irq_norm), 0);
        end

        // priority / routing patterns: R4 R5 R9
        for (int pat = 0; pat < 2; pat++) begin
            logic [31:0] fexp;
            for (int i = 0; i < NL; i++)
                wr(12'(256 + 4 * i), 32'((pr(pat, i) << 2) | 2 | int'(fr(pat, i))));
            rd(12'(256 + 4 * 17));
            chk("R4 line cfg readback", q, 32'((pr(pat, 17) << 2) | int'(fr(pat, 17))));
            irq_lines = '1;
            tick(); tick();
            chk("R6 normal fires all", 32'(irq_norm), 1);
            chk("R6 fast fires all", 32'(irq_fast), 1);
            rd(12'h040); chk("R5 normal winner", q, 32'(winner(pat, 1'b0)));
            rd(12'h044); chk("R5 fast winner", q, 32'(winner(pat, 1'b1)));
            fexp = '0;
            for (int k = 0; k < 32; k++) fexp[k] = fr(pat, 32 + k);
            rd(ba(1, 28)); chk("R9 fast pending", q, fexp);
            rd(ba(1, 24)); chk("R9 normal pending", q, ~fexp);
            irq_lines = '0;
            tick();
            wr(12'h048, 3);
            tick();
            chk("R6 rearm normal", 32'(irq_norm), 0);
            chk("R6 rearm fast", 32'(irq_fast), 0);
        end

        // R14 soft reset
        wr(12'h050, 2);
        wr(12'h010, 32'h3);
        rd(ba(1, 4));  chk("R14 mask reset", q, 32'hFFFF_FFFF);
        rd(12'h050);   chk("R14 idle reset", q, 0);
        rd(12'h010);   chk("R14 autoidle reset", q, 0);
        rd(12'h144);   chk("R14 line cfg reset", q, 0);
        for (int b = 0; b < 3; b++) wr(ba(b, 4), 0);

        // R8 global hold-off
        wr(12'h048, 4);
        rd(12'h048); chk("R8 control readback", q, 4);
        irq_lines[3] = 1'b1;
        tick(); tick();
        chk("R8 held off", 32'(irq_norm), 0);
        wr(12'h048, 1);
        tick();
        chk("R8 release with rearm", 32'(irq_norm), 1);
        rd(12'h040); chk("R8 code", q, 3);
        irq_lines[3] = 1'b0;
        tick();
        wr(12'h048, 1); tick();
        chk("R6 rearm idle", 32'(irq_norm), 0);

        // R7 evaluation events
        wr(12'h048, 4);
        irq_lines[20] = 1'b1;
        tick(); tick();
        chk("R7 held off", 32'(irq_norm), 0);
        wr(12'h048, 0); tick();
        chk("R7 hold-off release no eval", 32'(irq_norm), 0);
        wr(ba(0, 12), 32'h8000_0000); tick();
        chk("R7 mask-set no eval", 32'(irq_norm), 0);
        wr(ba(0, 8), 32'h8000_0000); tick();
        chk("R7 mask-clear evaluates", 32'(irq_norm), 1);
        rd(12'h040); chk("R7 code", q, 20);
        wr(ba(0, 12), 32'h0010_0000);
        rd(ba(0, 24)); chk("R9 masked hidden", q, 0);
        rd(ba(0, 0));  chk("R3 raw while masked", q, 32'h0010_0000);
        wr(ba(0, 8), 32'h0010_0000);
        rd(ba(0, 24)); chk("R9 unmasked visible", q, 32'h0010_0000);
        irq_lines[20] = 1'b0;
        tick();
        wr(12'h048, 1); tick();
        chk("R6 rearm idle 2", 32'(irq_norm), 0);

        // R11 R12 software interrupts
        wr(ba(1, 16), 32'h10); tick();
        chk("R11 sw-set fires", 32'(irq_norm), 1);
        rd(12'h040); chk("R11 sw code", q, 36);
        rd(12'h040); chk("R12 repeated code read", q, 36);
        rd(ba(1, 24)); chk("R12 pending kept", q, 32'h10);
        rd(ba(1, 16)); chk("R11 sw bits readback", q, 32'h10);
        rd(ba(1, 20)); chk("R3 sw-clear reads 0", q, 0);
        irq_lines[37] = 1'b1;
        tick();
        rd(ba(1, 24)); chk("R10 rise sets pending", q, 32'h30);
        wr(ba(1, 20), 0);
        rd(ba(1, 24)); chk("R11 clear recompute", q, 0);
        rd(ba(1, 16)); chk("R11 sw bits kept", q, 32'h10);
        irq_lines[37] = 1'b0;
        tick();
        rd(ba(1, 24)); chk("R10 fall keeps sw", q, 32'h10);
        wr(ba(1, 20), 32'h10);
        rd(ba(1, 24)); chk("R11 clear drops", q, 0);
        rd(ba(1, 16)); chk("R11 sw bits cleared", q, 0);
        wr(12'h048, 1); tick();
        chk("R6 rearm idle 3", 32'(irq_norm), 0);

        // R13 errors
        wr(12'h000, 32'h55); chk("R13 revision write err", 32'(e), 1);
        rd(12'h000); chk("R13 revision unchanged", q, 32'h21);
        chk("R13 valid read no err", 32'(e), 0);
        wr(ba(0, 24), 32'hFF); chk("R13 pending view write err", 32'(e), 1);
        wr(ba(0, 0), 32'hFF);  chk("R13 raw view write err", 32'(e), 1);
        wr(12'h040, 5);        chk("R13 code write err", 32'(e), 1);
        rd(12'h040); chk("R13 code unchanged", q, 36);
        rd(12'h0E0);           chk("R13 bank3 read err", 32'(e), 1);
        wr(12'h0E4, 0);        chk("R13 bank3 write err", 32'(e), 1);
        rd(12'h280);           chk("R13 past last line err", 32'(e), 1);
        rd(12'h004);           chk("R13 unmapped err", 32'(e), 1);
        rd(ba(0, 4)); chk("R13 mask unchanged", q, 0);
        chk("R13 err one cycle", 32'(e), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule